// File: doc/BRIEF.md
# Three-Bus Processor Datapath with Four-Step Fetch/Execute Sequencer

This block is a minimal processor core in which every register-to-register operation uses three internal buses. Two registers are read together, one onto bus A and one onto bus B. The ALU combines the two buses and drives its result onto bus C. Bus C is written back into the register file on the same clock edge. A separate incrementer advances the program counter, so the ALU is never used to step the PC. There are no temporary holding registers at the ALU inputs or output.

Each instruction takes four control steps:

1. The PC goes through the ALU as a pass of the B operand and is loaded into the memory address register. In the same cycle the PC advances by four.
2. A read request is held on the memory port until the memory signals function-complete. The returned word is then captured into the memory data register.
3. The memory data register is copied into the instruction register.
4. The instruction executes in one step and the sequencer returns to step 1.

Each register write is shown on a commit port, so the surrounding system can follow the architectural state.

Top module: `tbc_core`

## Requirements
- R1: While reset is low and on the first cycle after it, `mem_req` and `commit_en` are 0 and `mem_addr` is 0. All registers reset to 0.
- R2: The n-th fetch (counting from 0) presents `mem_addr` = 4*n. The MAR takes the PC value from before the increment, and the PC grows by exactly 4 per instruction.
- R3: `mem_req` rises in the cycle after the address step. It stays high for as many cycles as `mem_mfc` stays low, and it drops once `mem_mfc` has been sampled high on a rising edge.
- R4: `mem_rdata` is captured only on the edge where `mem_mfc` is high, and its value in other cycles has no effect. The captured word becomes the executed instruction two edges later.
- R5: Instruction format: opcode in bits [31:26], source-A register in [25:21], source-B register in [20:16], destination in [15:11]. Bits [10:0] are ignored.
- R6: Opcodes 0x00, 0x01, 0x02 and 0x03 write A+B, A-B, A AND B and A OR B (32-bit, wrapping) into the destination.
- R7: Opcode 0x04 writes A unchanged and opcode 0x05 writes B unchanged.
- R8: Opcode 0x06 selects the constant 4 on the B side and writes A+4.
- R9: A result is in the register file at the end of its execute step, so the next instruction reads the new value.
- R10: Any other opcode writes nothing: `commit_en` stays 0 and every register keeps its value.
- R11: With `mem_mfc` returned on the first request cycle, one instruction takes exactly 4 cycles. Each cycle of memory wait adds one cycle.
- R12: `commit_en` is high only during the execute step, and then `commit_reg`/`commit_data` carry the destination and the value written from bus C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | output | 1 | Read request, held until function-complete |
| mem_addr | output | 32 | Memory address register contents |
| mem_mfc | input | 1 | Memory function complete |
| mem_rdata | input | 32 | Read data, valid while `mem_mfc` is high |
| commit_en | output | 1 | Register write in this cycle |
| commit_reg | output | 5 | Destination register of the write |
| commit_data | output | 32 | Value written (bus C) |

## Verification
The assertions assume the following about the memory side:
- The memory raises `mem_mfc` only while `mem_req` is high.
- `mem_mfc` is held for a single cycle.
- `mem_rdata` is meaningful only in that cycle.

The bench memory model keeps to these rules. It answers each request after a random wait of zero to several cycles, pulses `mem_mfc` for exactly one cycle, and drives random junk on `mem_rdata` at all other times, so the check on capture timing has something to catch. Programs mix directed dependency chains and undefined opcodes with random instructions confined to a few registers, so that results are often read back by the next instruction.

// File: rtl/tbc_pkg.sv
// Package: shared widths, opcode values, ALU operation and control-step types
// for the three-bus core. Assumes a 32-bit word and 5-bit register fields.
package tbc_pkg;
    localparam int WORD_W  = 32;
    localparam int OPC_W   = 6;
    localparam int RFLD_W  = 5;
    localparam int PC_STEP = 4;

    // Instruction field positions (the decoder depends on them)
    localparam int OPC_LSB = 26;
    localparam int SRA_LSB = 21;
    localparam int SRB_LSB = 16;
    localparam int DST_LSB = 11;

    localparam logic [OPC_W-1:0] OPC_ADD  = 6'h00;
    localparam logic [OPC_W-1:0] OPC_SUB  = 6'h01;
    localparam logic [OPC_W-1:0] OPC_AND  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_OR   = 6'h03;
    localparam logic [OPC_W-1:0] OPC_MOVA = 6'h04;
    localparam logic [OPC_W-1:0] OPC_MOVB = 6'h05;
    localparam logic [OPC_W-1:0] OPC_ADDK = 6'h06;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_PASS_A, ALU_PASS_B
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_ADDR, ST_WAIT, ST_LOAD_IR, ST_EXEC
    } step_e;
endpackage

// File: rtl/tbc_regfile.sv
// Register file with two asynchronous read ports (buses A and B) and one
// synchronous write port (bus C). Assumes one write per cycle; a read of the
// register written on the previous edge returns the new value.
module tbc_regfile #(
    parameter int DATA_W  = tbc_pkg::WORD_W,
    parameter int REG_CNT = 32,
    localparam int IDX_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_a_val,
    output logic [DATA_W-1:0] rd_b_val,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_val
);
    logic [DATA_W-1:0] cells [REG_CNT];

    // Storage: clear on reset, load bus C on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_CNT; i++) cells[i] <= '0;
        end else if (wr_en) begin
            cells[wr_idx] <= wr_val;
        end
    end

    // Read ports onto buses A and B
    always_comb begin
        rd_a_val = cells[rd_a_idx];
        rd_b_val = cells[rd_b_idx];
    end

    // R9
    wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(rst_n) && rd_a_idx == $past(wr_idx)) |-> rd_a_val == $past(wr_val));
endmodule

// File: rtl/tbc_alu.sv
// ALU between the buses: operands from buses A and B, result to bus C.
// Purely combinational; arithmetic wraps at DATA_W bits.
module tbc_alu #(
    parameter int DATA_W = tbc_pkg::WORD_W
) (
    input  tbc_pkg::alu_op_e  op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] res
);
    import tbc_pkg::*;

    // Operation select
    always_comb begin
        case (op)
            ALU_ADD:    res = opnd_a + opnd_b;
            ALU_SUB:    res = opnd_a - opnd_b;
            ALU_AND:    res = opnd_a & opnd_b;
            ALU_OR:     res = opnd_a | opnd_b;
            ALU_PASS_A: res = opnd_a;
            default:    res = opnd_b;
        endcase
    end
endmodule

// File: rtl/tbc_decode.sv
// Instruction decoder: splits the instruction register into register fields
// and maps the opcode to an ALU operation, B-constant select and write enable.
// Assumes the fixed field layout of tbc_pkg; undefined opcodes write nothing.
module tbc_decode #(
    parameter int DATA_W = tbc_pkg::WORD_W,
    parameter int IDX_W  = tbc_pkg::RFLD_W
) (
    input  logic [DATA_W-1:0] instr,
    output tbc_pkg::alu_op_e  op,
    output logic              use_k4,
    output logic              wr_ok,
    output logic [IDX_W-1:0]  src_a,
    output logic [IDX_W-1:0]  src_b,
    output logic [IDX_W-1:0]  dst
);
    import tbc_pkg::*;

    logic [OPC_W-1:0] opc;
    logic             unused_low;

    // Field extraction
    always_comb begin
        opc        = instr[OPC_LSB +: OPC_W];
        src_a      = instr[SRA_LSB +: IDX_W];
        src_b      = instr[SRB_LSB +: IDX_W];
        dst        = instr[DST_LSB +: IDX_W];
        unused_low = ^instr[DST_LSB-1:0];
    end

    // Opcode to control mapping
    always_comb begin
        op     = ALU_ADD;
        use_k4 = 1'b0;
        wr_ok  = 1'b1;
        case (opc)
            OPC_ADD:  op = ALU_ADD;
            OPC_SUB:  op = ALU_SUB;
            OPC_AND:  op = ALU_AND;
            OPC_OR:   op = ALU_OR;
            OPC_MOVA: op = ALU_PASS_A;
            OPC_MOVB: op = ALU_PASS_B;
            OPC_ADDK: use_k4 = 1'b1;
            default:  wr_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/tbc_seq.sv
// Four-step control sequencer: address, wait for memory-function-complete,
// load instruction register, execute. Assumes mem_mfc is only raised while
// the read request is high.
module tbc_seq (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_mfc,
    output tbc_pkg::step_e   step,
    output logic             mem_req
);
    import tbc_pkg::*;

    step_e step_q, step_d;

    // Next-step selection
    always_comb begin
        step_d = step_q;
        case (step_q)
            ST_ADDR:    step_d = ST_WAIT;
            ST_WAIT:    step_d = mem_mfc ? ST_LOAD_IR : ST_WAIT;
            ST_LOAD_IR: step_d = ST_EXEC;
            default:    step_d = ST_ADDR;
        endcase
    end

    // Step register
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_ADDR;
        else        step_q <= step_d;
    end

    assign step    = step_q;
    assign mem_req = (step_q == ST_WAIT);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_mfc) |=> mem_req);
    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_mfc) |=> !mem_req);
    // R11
    exec_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_EXEC) |=> (step_q == ST_ADDR));
endmodule

// File: rtl/tbc_core.sv
// Three-bus core top: PC with dedicated incrementer, MAR, MDR and IR around
// a three-port register file and ALU. Bus B carries the PC during the
// address step, the constant 4 for the add-constant opcode, or register B.
module tbc_core #(
    parameter int DATA_W  = tbc_pkg::WORD_W,
    parameter int REG_CNT = 32,
    localparam int IDX_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_mfc,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              commit_en,
    output logic [IDX_W-1:0]  commit_reg,
    output logic [DATA_W-1:0] commit_data
);
    import tbc_pkg::*;

    step_e             step;
    logic [DATA_W-1:0] pc_q, mar_q, mdr_q, ir_q;
    logic [DATA_W-1:0] bus_a, bus_b, bus_c, rf_b, pc_inc;
    alu_op_e           dec_op, alu_op;
    logic              dec_k4, dec_wr;
    logic [IDX_W-1:0]  f_sa, f_sb, f_dst;

    tbc_seq seq_i (
        .clk(clk), .rst_n(rst_n), .mem_mfc(mem_mfc),
        .step(step), .mem_req(mem_req)
    );

    tbc_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) dec_i (
        .instr(ir_q), .op(dec_op), .use_k4(dec_k4), .wr_ok(dec_wr),
        .src_a(f_sa), .src_b(f_sb), .dst(f_dst)
    );

    tbc_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) rf_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(f_sa), .rd_b_idx(f_sb),
        .rd_a_val(bus_a), .rd_b_val(rf_b),
        .wr_en(commit_en), .wr_idx(f_dst), .wr_val(bus_c)
    );

    tbc_alu #(.DATA_W(DATA_W)) alu_i (
        .op(alu_op), .opnd_a(bus_a), .opnd_b(bus_b), .res(bus_c)
    );

    // Bus B source and ALU operation per step
    always_comb begin
        pc_inc = pc_q + DATA_W'(PC_STEP);
        if (step == ST_ADDR) begin
            bus_b  = pc_q;
            alu_op = ALU_PASS_B;
        end else begin
            bus_b  = dec_k4 ? DATA_W'(PC_STEP) : rf_b;
            alu_op = dec_op;
        end
    end

    // PC and MAR: address step copies PC over bus C and advances the PC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
        end else if (step == ST_ADDR) begin
            mar_q <= bus_c;
            pc_q  <= pc_inc;
        end
    end

    // MDR and IR: capture memory data on completion, then move to IR
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q <= '0;
            ir_q  <= '0;
        end else begin
            if (step == ST_WAIT && mem_mfc) mdr_q <= mem_rdata;
            if (step == ST_LOAD_IR)         ir_q  <= mdr_q;
        end
    end

    assign mem_addr    = mar_q;
    assign commit_en   = (step == ST_EXEC) && dec_wr;
    assign commit_reg  = f_dst;
    assign commit_data = bus_c;

    // R2
    mar_old_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step) == ST_ADDR) |-> (mar_q == $past(pc_q) && pc_q == $past(pc_q) + DATA_W'(PC_STEP)));
    // R2
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00);
    // R12
    commit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> !mem_req);
    // R4
    mdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mem_mfc)) |-> $stable(mdr_q));
endmodule

// File: tb/tbc_core_tb.sv
// Self-checking bench: memory model with random wait, reference register model.
module tbc_core_tb_top;
    localparam int NPROG = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_mfc = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        commit_en;
    logic [4:0]  commit_reg;
    logic [31:0] commit_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    longint cyc = 0;

    logic [31:0] prog [NPROG];
    int          lat  [NPROG];
    logic [31:0] ref_rf [32];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tbc_core dut_i (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_mfc(mem_mfc), .mem_rdata(mem_rdata), .commit_en(commit_en),
        .commit_reg(commit_reg), .commit_data(commit_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int opc, input int a, input int b, input int d);
        return {opc[5:0], a[4:0], b[4:0], d[4:0], 11'h5A5};
    endfunction

    function automatic bit opc_valid(input logic [5:0] o);
        return o <= 6'h06;
    endfunction

    function automatic logic [31:0] ref_res(input logic [31:0] ins);
        logic [31:0] a, b;
        a = ref_rf[ins[25:21]];
        b = ref_rf[ins[20:16]];
        case (ins[31:26])
            6'h00: return a + b;
            6'h01: return a - b;
            6'h02: return a & b;
            6'h03: return a | b;
            6'h04: return a;
            6'h05: return b;
            default: return a + 32'd4;
        endcase
    endfunction

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        longint last_cyc;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 32; i++) ref_rf[i] = '0;
        // Directed start: dependency chain, wrap, undefined opcodes
        prog[0]  = mk(6, 0, 0, 1);   // r1 = 4           R8
        prog[1]  = mk(0, 1, 1, 2);   // r2 = 8           R6 R9
        prog[2]  = mk(1, 0, 2, 3);   // r3 = -8          R6
        prog[3]  = mk(3, 3, 1, 4);   // OR               R6
        prog[4]  = mk(2, 3, 2, 5);   // AND              R6
        prog[5]  = mk(4, 3, 9, 6);   // pass A           R7
        prog[6]  = mk(5, 9, 2, 7);   // pass B           R7
        prog[7]  = mk(7, 2, 2, 1);   // undefined        R10
        prog[8]  = mk(63, 2, 2, 1);  // undefined        R10
        prog[9]  = mk(4, 1, 0, 8);   // read r1 back     R10
        for (int i = 10; i < NPROG; i++) begin
            int o;
            o = ($urandom % 10 == 0) ? 8 + ($urandom % 56) : $urandom % 7;
            prog[i] = mk(o, $urandom % 8, $urandom % 8, $urandom % 8);
            prog[i][10:0] = 11'($urandom);
        end
        for (int i = 0; i < NPROG; i++) lat[i] = $urandom % 6;
        lat[0] = 0; lat[1] = 0; lat[2] = 7;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(mem_req == 1'b0 && commit_en == 1'b0 && mem_addr == 32'd0, "R1 reset", {30'd0, mem_req, commit_en}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        check(mem_req == 1'b0 && commit_en == 1'b0 && mem_addr == 32'd0, "R1 first cycle", mem_addr, 32'd0);

        last_cyc = 0;
        for (int k = 0; k < NPROG; k++) begin
            logic [31:0] ins;
            logic [31:0] exp;
            bit          wr;
            while (!mem_req) begin
                mem_rdata = $urandom;
                @(negedge clk);
            end
            check(mem_addr == 32'(4 * k), "R2 fetch address", mem_addr, 32'(4 * k));
            if (k > 0)
                check(cyc - last_cyc == longint'(4 + lat[k-1]), "R11 instruction cycles",
                      32'(cyc - last_cyc), 32'(4 + lat[k-1]));
            last_cyc = cyc;
            for (int w = 0; w < lat[k]; w++) begin
                mem_rdata = $urandom;   // R4: junk without mfc must be ignored
                @(negedge clk);
                check(mem_req == 1'b1, "R3 request held", {31'd0, mem_req}, 32'd1);
            end
            mem_mfc   = 1'b1;
            mem_rdata = prog[k];
            @(negedge clk);
            mem_mfc   = 1'b0;
            mem_rdata = $urandom;
            check(mem_req == 1'b0 && commit_en == 1'b0, "R3 request drops", {30'd0, mem_req, commit_en}, 32'd0);
            @(negedge clk);
            ins = prog[k];
            wr  = opc_valid(ins[31:26]);
            exp = ref_res(ins);
            check(commit_en == wr, "R10/R12 commit enable", {31'd0, commit_en}, {31'd0, wr});
            if (wr) begin
                check(commit_reg == ins[15:11], "R5 destination field", {27'd0, commit_reg}, {27'd0, ins[15:11]});
                check(commit_data == exp, "R4/R6/R7/R8/R9 result", commit_data, exp);
                ref_rf[ins[15:11]] = exp;
            end
            @(negedge clk);
            check(commit_en == 1'b0 && mem_req == 1'b0, "R12 commit only in execute", {31'd0, commit_en}, 32'd0);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule